// File: doc/BRIEF.md
# Two-Channel Waveform Generator for a 12-Bit DAC

This block is the digital front end in front of two 12-bit converters. For each channel it keeps a right-aligned 12-bit holding value. On top of that value it can lay a triangle wave or pseudo-random noise, with a programmable amplitude. The result is saturated and presented as the 12-bit code for that channel's converter.

The waveform moves on only when the channel's selected trigger fires. That trigger is one of seven hardware event lines or a per-channel software trigger bit. Each channel has its own configuration fields, so the two channels can step independently, or step together by picking the same event line.

Each channel runs a small state machine with three states:
- **OFF**: the channel is disabled, its output is zero and its wave state is at its reset values.
- **RISE**: the triangle counts up.
- **FALL**: the triangle counts down.

The transitions are:
- **enable** (OFF to RISE): at the first clock edge that sees the channel enable high.
- **disable** (RISE or FALL to OFF): at any edge that sees the enable low.
- **peak** (RISE to FALL): a triangle step taken with the count at or above the amplitude limit.
- **floor** (FALL to RISE): a triangle step taken with the count at zero.

Top module: `dac_wavegen`

## Requirements
- R1: After reset every `dac_code` slice is 0 and every `sw_trig_pend` bit is 0.
- R2: While a channel is in OFF its code is 0. The edge that sees `ch_en` high moves it to RISE, with the triangle count at 0 and the noise register at 12'hACE. A trigger at that edge does not step. Any edge that sees `ch_en` low returns it to OFF and restores those values.
- R3: With wave select 2'b00 the code equals the holding value, and triggers leave the output unchanged.
- R4: With wave select 2'b10 each step changes the triangle count as follows:
  - In RISE, a count below the limit goes up by one. A count at or above the limit goes down by one, and the state changes to FALL.
  - In FALL, a nonzero count goes down by one. A count of zero becomes 1, and the state changes to RISE.
  - The limit is 2^(a+1)-1 for amplitude code a up to 11. Codes 11 (4'b1011) and above give 4095.
- R5: The code is holding value plus wave value, saturated at 4095.
- R6: With wave select 2'b01 the wave value is the 12-bit noise register ANDed with the amplitude limit. Each step replaces the register s with {s[10:0], s[11]^s[5]^s[3]^s[0]}. The register never becomes zero.
- R7: Trigger select 3'b111 chooses the software trigger. A pulse on `sw_trig_set` sets `sw_trig_pend` at that edge. At the next edge, if the trigger is enabled, one step is taken and the bit is cleared. A new set pulse has priority over the clear.
- R8: Trigger select values 0 to 6 choose `hw_evt` bit of that index. One step is taken at every edge where that bit is high and the trigger is enabled. The code shows the step right after that edge.
- R9: With trigger enable low, neither the triangle nor the noise advances, and a pending software trigger bit stays set.
- R10: Wave select 2'b11 behaves as no wave: the code equals the holding value.
- R11: The two channels step independently. Two channels that select the same event line step at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NCH | Channel enable, one bit per channel |
| trig_en | input | NCH | Trigger enable, one bit per channel |
| trig_sel | input | 3*NCH | Trigger select per channel; 3'b111 selects the software trigger |
| wave_sel | input | 2*NCH | Wave select per channel: 00 none, 01 noise, 10 triangle, 11 none |
| amp_sel | input | 4*NCH | Amplitude code per channel |
| hold_val | input | 12*NCH | Right-aligned holding value per channel |
| hw_evt | input | 7 | Hardware trigger event lines, indexed by trigger select |
| sw_trig_set | input | NCH | Pulse that sets the channel's software trigger bit |
| sw_trig_pend | output | NCH | Software trigger bit; cleared by hardware when its step is taken |
| dac_code | output | 12*NCH | 12-bit code presented to each converter |

## Verification
The hardest state to reach is the full-amplitude turnaround. Getting there takes 4095 triangle steps before the peak and 4095 more before the floor. The bench holds an event line high for over 8190 cycles and checks every intermediate code against an arithmetic model, including the 4095 peak.

A second hard case is an amplitude change that leaves the count above the new limit. A long pseudo-random sweep changes amplitude, wave, trigger source, enables and the software bits every cycle while both channels run, so it lands in that state and in disable/re-enable corners that directed tests miss.

// File: rtl/dac_wg_pkg.sv
package dac_wg_pkg;
    localparam int CODE_W  = 12;
    localparam int TRIG_W  = 3;
    localparam int AMP_W   = 4;
    localparam int WAVE_W  = 2;
    localparam int NSRC    = (1 << TRIG_W) - 1;
    localparam logic [TRIG_W-1:0] TRIG_SW    = '1;
    localparam logic [CODE_W-1:0] NOISE_SEED = 12'hACE;
    localparam logic [CODE_W-1:0] CODE_ONE   = {{(CODE_W-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {CH_OFF = 2'd0, CH_RISE = 2'd1, CH_FALL = 2'd2} ch_state_e;
    typedef enum logic [WAVE_W-1:0] {WV_NONE = 2'd0, WV_NOISE = 2'd1, WV_TRI = 2'd2, WV_RSVD = 2'd3} wave_e;

    function automatic logic [CODE_W-1:0] amp_limit(input logic [AMP_W-1:0] a);
        logic [CODE_W:0] t;
        if (a >= AMP_W'(CODE_W - 1)) return '1;
        t = ((CODE_W+1)'(1) << (a + AMP_W'(1))) - (CODE_W+1)'(1);
        return t[CODE_W-1:0];
    endfunction

    function automatic logic [CODE_W-1:0] noise_next(input logic [CODE_W-1:0] s);
        return {s[CODE_W-2:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction
endpackage

// File: rtl/dac_wg_trig.sv
module dac_wg_trig
    import dac_wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              trig_en,
    input  logic [TRIG_W-1:0] trig_sel,
    input  logic [NSRC-1:0]   hw_evt,
    input  logic              sw_set,
    output logic              step,
    output logic              sw_pend
);
    logic                  pend_q;
    logic [(1<<TRIG_W)-1:0] src;

    assign src     = {pend_q, hw_evt};
    assign step    = live & trig_en & src[trig_sel];
    assign sw_pend = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= sw_set | (pend_q & ~(step & (trig_sel == TRIG_SW)));
    end

    // R7
    sw_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && trig_sel == TRIG_SW && !sw_set) |=> !pend_q);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !trig_en) |=> pend_q);
endmodule

// File: rtl/dac_wg_wave.sv
module dac_wg_wave
    import dac_wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              step,
    input  logic [WAVE_W-1:0] wave_sel,
    input  logic [AMP_W-1:0]  amp_sel,
    output logic              live,
    output logic              on,
    output logic [CODE_W-1:0] wave_val
);
    ch_state_e          state_q, state_d;
    logic [CODE_W-1:0]  tri_q, tri_d, lfsr_q, lfsr_d, lim;
    wave_e              wv;

    assign wv   = wave_e'(wave_sel);
    assign lim  = amp_limit(amp_sel);
    assign on   = (state_q != CH_OFF);
    assign live = on & ch_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            tri_q   <= '0;
            lfsr_q  <= NOISE_SEED;
        end else begin
            state_q <= state_d;
            tri_q   <= tri_d;
            lfsr_q  <= lfsr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tri_d   = tri_q;
        lfsr_d  = lfsr_q;
        unique case (state_q)
            CH_OFF: begin
                tri_d  = '0;
                lfsr_d = NOISE_SEED;
                if (ch_en) state_d = CH_RISE;
            end
            CH_RISE: begin
                if (step && wv == WV_TRI) begin
                    if (tri_q >= lim) begin
                        state_d = CH_FALL;
                        tri_d   = tri_q - CODE_ONE;
                    end else begin
                        tri_d   = tri_q + CODE_ONE;
                    end
                end
            end
            CH_FALL: begin
                if (step && wv == WV_TRI) begin
                    if (tri_q == '0) begin
                        state_d = CH_RISE;
                        tri_d   = CODE_ONE;
                    end else begin
                        tri_d   = tri_q - CODE_ONE;
                    end
                end
            end
            default: state_d = CH_OFF;
        endcase
        if (live && step && wv == WV_NOISE) lfsr_d = noise_next(lfsr_q);
        if (!ch_en) begin
            state_d = CH_OFF;
            tri_d   = '0;
            lfsr_d  = NOISE_SEED;
        end
    end

    always_comb begin
        unique case (wv)
            WV_NOISE: wave_val = lfsr_q & lim;
            WV_TRI:   wave_val = tri_q;
            default:  wave_val = '0;
        endcase
    end

    // R2
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |-> (tri_q == '0 && lfsr_q == NOISE_SEED));

    // R6
    noise_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF && ch_en && !step) |=> ($stable(tri_q) && $stable(lfsr_q)));

    // R4
    tri_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RISE && ch_en && step && wv == WV_TRI && tri_q < lim)
        |=> (tri_q == $past(tri_q) + CODE_ONE));
endmodule

// File: rtl/dac_wg_sum.sv
module dac_wg_sum
    import dac_wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on,
    input  logic [CODE_W-1:0] hold,
    input  logic [CODE_W-1:0] wave_val,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W:0] sum;

    assign sum  = {1'b0, hold} + {1'b0, wave_val};
    assign code = !on ? '0 : (sum[CODE_W] ? '1 : sum[CODE_W-1:0]);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> (code >= hold));
endmodule

// File: rtl/dac_wavegen.sv
module dac_wavegen
    import dac_wg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ch_en,
    input  logic [NCH-1:0]        trig_en,
    input  logic [NCH*TRIG_W-1:0] trig_sel,
    input  logic [NCH*WAVE_W-1:0] wave_sel,
    input  logic [NCH*AMP_W-1:0]  amp_sel,
    input  logic [NCH*CODE_W-1:0] hold_val,
    input  logic [NSRC-1:0]       hw_evt,
    input  logic [NCH-1:0]        sw_trig_set,
    output logic [NCH-1:0]        sw_trig_pend,
    output logic [NCH*CODE_W-1:0] dac_code
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              live, on, step;
        logic [CODE_W-1:0] wave_val;

        dac_wg_trig i_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (live),
            .trig_en  (trig_en[c]),
            .trig_sel (trig_sel[c*TRIG_W +: TRIG_W]),
            .hw_evt   (hw_evt),
            .sw_set   (sw_trig_set[c]),
            .step     (step),
            .sw_pend  (sw_trig_pend[c])
        );

        dac_wg_wave i_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .ch_en    (ch_en[c]),
            .step     (step),
            .wave_sel (wave_sel[c*WAVE_W +: WAVE_W]),
            .amp_sel  (amp_sel[c*AMP_W +: AMP_W]),
            .live     (live),
            .on       (on),
            .wave_val (wave_val)
        );

        dac_wg_sum i_sum (
            .clk      (clk),
            .rst_n    (rst_n),
            .on       (on),
            .hold     (hold_val[c*CODE_W +: CODE_W]),
            .wave_val (wave_val),
            .code     (dac_code[c*CODE_W +: CODE_W])
        );
    end
endmodule

// File: tb/test_dac_wavegen.sv
module test_dac_wavegen;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam logic [11:0] SEED = 12'hACE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_en = '0, trig_en = '0, sw_set = '0;
    logic [NCH*3-1:0]  trig_sel = '0;
    logic [NCH*2-1:0]  wave_sel = '0;
    logic [NCH*4-1:0]  amp_sel = '0;
    logic [NCH*12-1:0] hold_val = '0;
    logic [6:0]        hw_evt = '0;
    logic [NCH-1:0]    sw_pend;
    logic [NCH*12-1:0] dac_code;

    int n_chk = 0, n_bad = 0, peak = 0;
    string cur_req = "R1";
    bit done = 0;

    int          m_tri[NCH];
    bit          m_up[NCH], m_off[NCH], m_pend[NCH];
    logic [11:0] m_lfsr[NCH];

    dac_wavegen #(.NCH(NCH)) i_dac_wavegen (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .trig_en(trig_en),
        .trig_sel(trig_sel), .wave_sel(wave_sel), .amp_sel(amp_sel),
        .hold_val(hold_val), .hw_evt(hw_evt), .sw_trig_set(sw_set),
        .sw_trig_pend(sw_pend), .dac_code(dac_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim_of(int a);
        return (a >= 11) ? 4095 : ((1 << (a + 1)) - 1);
    endfunction

    function automatic logic [11:0] nz_next(logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    function automatic int exp_code(int c);
        int w, s, a;
        if (m_off[c]) return 0;
        a = int'(amp_sel[c*4 +: 4]);
        case (wave_sel[c*2 +: 2])
            2'b01:   w = int'(m_lfsr[c]) & lim_of(a);
            2'b10:   w = m_tri[c];
            default: w = 0;
        endcase
        s = int'(hold_val[c*12 +: 12]) + w;
        return (s > 4095) ? 4095 : s;
    endfunction

    task automatic model_update();
        for (int c = 0; c < NCH; c++) begin
            int sel, lim;
            bit st;
            sel = int'(trig_sel[c*3 +: 3]);
            lim = lim_of(int'(amp_sel[c*4 +: 4]));
            st = 0;
            if (!ch_en[c]) begin
                m_off[c] = 1; m_tri[c] = 0; m_up[c] = 1; m_lfsr[c] = SEED;
            end else if (m_off[c]) begin
                m_off[c] = 0;
            end else begin
                st = trig_en[c] && ((sel == 7) ? m_pend[c] : hw_evt[sel]);
                if (st && wave_sel[c*2 +: 2] == 2'b10) begin
                    if (m_up[c]) begin
                        if (m_tri[c] >= lim) begin m_up[c] = 0; m_tri[c]--; end
                        else m_tri[c]++;
                    end else begin
                        if (m_tri[c] == 0) begin m_up[c] = 1; m_tri[c] = 1; end
                        else m_tri[c]--;
                    end
                end
                if (st && wave_sel[c*2 +: 2] == 2'b01) m_lfsr[c] = nz_next(m_lfsr[c]);
            end
            m_pend[c] = sw_set[c] | (m_pend[c] & !(st && sel == 7));
        end
    endtask

    task automatic compare();
        for (int c = 0; c < NCH; c++) begin
            int got;
            got = int'(dac_code[c*12 +: 12]);
            if (got > peak) peak = got;
            n_chk++;
            if (got != exp_code(c)) begin
                n_bad++;
                $display("FAIL %s ch%0d code actual=%0d expected=%0d", cur_req, c, got, exp_code(c));
            end
            n_chk++;
            if (sw_pend[c] != m_pend[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d pend actual=%0d expected=%0d", cur_req, c, sw_pend[c], m_pend[c]);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        #1;
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int rs;
        for (int c = 0; c < NCH; c++) begin
            m_tri[c] = 0; m_up[c] = 1; m_off[c] = 1; m_pend[c] = 0; m_lfsr[c] = SEED;
        end
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 compare();
        rst_n = 1'b1;

        // R3: no wave, hardware pulses must not move the code
        cur_req = "R3";
        ch_en = 2'b01; trig_en = 2'b01; hold_val[11:0] = 12'd123;
        tick();
        for (int i = 0; i < 10; i++) begin
            hw_evt[0] = i[0];
            tick();
        end

        // R4 R8: triangle, amplitude 2, event line 3 on alternate cycles
        cur_req = "R4 R8";
        wave_sel[1:0] = 2'b10; amp_sel[3:0] = 4'd2; trig_sel[2:0] = 3'd3; hold_val[11:0] = 12'd100;
        for (int i = 0; i < 50; i++) begin
            hw_evt = (i % 2 == 0) ? 7'b0001000 : 7'b0000001;
            tick();
        end

        // R2: disable then re-enable restarts the triangle from zero
        cur_req = "R2";
        ch_en[0] = 1'b0; hw_evt = 7'b0001000;
        ticks(3);
        ch_en[0] = 1'b1;
        ticks(6);
        hw_evt = '0;

        // R4: full amplitude 4'b1011 peaks at 4095 and turns around
        cur_req = "R4 full";
        amp_sel[3:0] = 4'b1011; hold_val[11:0] = 12'd0; trig_sel[2:0] = 3'd0;
        ch_en[0] = 1'b0; tick(); ch_en[0] = 1'b1; tick();
        peak = 0;
        hw_evt = 7'b0000001;
        ticks(8200);
        hw_evt = '0;
        n_chk++;
        if (peak != 4095) begin
            n_bad++;
            $display("FAIL R4 peak actual=%0d expected=4095", peak);
        end

        // R5: saturation of hold + triangle
        cur_req = "R5";
        amp_sel[3:0] = 4'd7; hold_val[11:0] = 12'd4000; hw_evt = 7'b0000001;
        ticks(600);
        hw_evt = '0;

        // R6: noise with amplitude sweep and near-full hold
        cur_req = "R6";
        wave_sel[1:0] = 2'b01; hold_val[11:0] = 12'd50;
        for (int a = 0; a < 16; a++) begin
            amp_sel[3:0] = 4'(a);
            hw_evt = 7'b0000001; ticks(20);
            hw_evt = '0; tick();
        end
        hold_val[11:0] = 12'd4090; hw_evt = 7'b0000001;
        ticks(30);
        hw_evt = '0;

        // R10: reserved wave select behaves as none
        cur_req = "R10";
        wave_sel[1:0] = 2'b11; hold_val[11:0] = 12'd777; hw_evt = 7'b0000001;
        ticks(8);
        hw_evt = '0;

        // R7: software trigger on channel 1
        cur_req = "R7";
        ch_en[1] = 1'b1; trig_en[1] = 1'b1; trig_sel[5:3] = 3'b111;
        wave_sel[3:2] = 2'b10; amp_sel[7:4] = 4'd3; hold_val[23:12] = 12'd10;
        tick();
        for (int i = 0; i < 12; i++) begin
            sw_set[1] = 1'b1; tick();
            sw_set[1] = 1'b0; ticks(2);
        end
        sw_set[1] = 1'b1; ticks(4); sw_set[1] = 1'b0; ticks(2);

        // R9: trigger disabled, pending bit stays and nothing steps
        cur_req = "R9";
        trig_en[1] = 1'b0;
        sw_set[1] = 1'b1; tick(); sw_set[1] = 1'b0;
        ticks(6);
        trig_en[0] = 1'b0; wave_sel[1:0] = 2'b10; hw_evt = 7'b0000001;
        ticks(6);
        trig_en[1] = 1'b1; ticks(2);
        hw_evt = '0;

        // R11: both channels on the same event line, different amplitudes
        cur_req = "R11";
        trig_en = 2'b11; trig_sel = {3'd5, 3'd5};
        wave_sel = {2'b10, 2'b10}; amp_sel = {4'd1, 4'd4};
        hold_val = {12'd200, 12'd300};
        for (int i = 0; i < 60; i++) begin
            hw_evt = (i % 3 == 0) ? 7'b0100000 : 7'b0000000;
            tick();
        end

        // R2 R4 R6 R7 R8 R9 R11: pseudo-random sweep of every field
        cur_req = "R2 R4 R6 R7 R8 R9 R11 sweep";
        rs = 32'h1234567;
        for (int i = 0; i < 4000; i++) begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >>> 17); rs = rs ^ (rs << 5);
            hw_evt   = rs[6:0];
            trig_sel = rs[12:7];
            wave_sel = rs[16:13];
            if (rs[20:17] == 4'd0) amp_sel = rs[28:21];
            sw_set   = rs[30:29];
            trig_en  = (rs[31] | rs[0]) ? 2'b11 : 2'b01;
            ch_en    = (rs[24:22] == 3'd0) ? rs[26:25] : 2'b11;
            if (rs[9:7] == 3'd1) hold_val = {rs[11:0], rs[27:16]};
            tick();
        end

        done = 1;
        summary();
    end
endmodule